// File: doc/BRIEF.md
# Quad Down-Counting Timer

The block is a memory-mapped timer with four independent down-counters behind a small register port. The port has an address, a write enable, write data and read data. Writes take effect at the clock edge. Reads are combinational from the addressed register, so a read completes in the cycle it is presented.

Each channel has:
- an immediate load register;
- a readable count;
- a control register;
- a deferred reload register.

The control register selects enable, a tick divider (1, 16 or 256), 16- or 32-bit counting, periodic or free-running reload, and one-shot stop. Software that wants an up-counting timestamp inverts the count.

A channel flags a raw event when a tick takes its count from one to zero. A shared group of registers masks those events, reports raw and masked status, and clears them. The single interrupt line is active while any masked event is pending.

Top module: `quad_timer`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: Addresses are byte-based, and only word-aligned accesses (address bits 1:0 = 00) are decoded.
  - Shared registers: 0x00 is the event mask (read/write, bit n belongs to channel n), 0x04 raw events (read-only), 0x08 masked events (read-only), 0x0C event clear (write-only, reads 0).
  - Channel n occupies 0x10+0x10·n: +0x0 immediate load, +0x4 count (read-only), +0x8 control, +0xC deferred reload.
  - The immediate load register reads back the current reload value.
  - Control keeps only bits 7, 6, 3, 2, 1 and 0; other bits read 0.
  - Any other address reads 0, and writes to it change nothing.
- R3: A write to the immediate load register places the data into the count on the next cycle and also replaces the reload value.
- R4: Control bit 7 enables the channel. An enabled channel subtracts one from a nonzero count on each tick. A disabled channel holds its count.
- R5: Control bits 3:2 set the tick divider: 00 gives a tick every cycle, 01 every 16 cycles, 10 or 11 every 256 cycles. The divider restarts whenever the channel is disabled or its load register is written, so the first tick after a load comes one full divider period later.
- R6: With control bit 1 clear the count is 16 bits wide. Loads keep only data bits 15:0, and the count reads back with bits 31:16 zero. With bit 1 set the count uses all 32 bits.
- R7: With control bits 6 and 0 clear, a tick on a zero count reloads all ones of the current width (0xFFFF or 0xFFFFFFFF).
- R8: With control bit 6 set (and bit 0 clear), a tick on a zero count reloads the reload value, cut to the current width. A write to the deferred reload register never changes the running count.
- R9: With control bit 0 set, the count stays at zero until the load register is written again.
- R10: A channel's raw event bit sets on the tick that takes its count from 1 to 0. Writing 1 to bit n of the clear register clears bit n. A new event in the same cycle wins over the clear.
- R11: Masked events equal raw events ANDed with the mask, and `irq` is high exactly while any masked event is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the access |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined masked event output |

## Verification
The bench builds the block with its default parameters: four channels, a 32-bit count, a 16-bit narrow mode and divider steps of 16 and 256. With small load values, the narrow mode brings the free-running wrap to 0xFFFF within a few dozen cycles. A zero load in 32-bit mode reaches the full-width wrap on the next tick. A one-shot channel on the 256 divider stays reachable within a thousand cycles, so every reload rule and both divider steps are observed in a short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Per-channel write strobes sent from the control side to the datapath.
  typedef struct packed {
    logic loadWr;
    logic reloadWr;
    logic ctlWr;
  } chanStrobe_t;

  localparam int unsigned CTL_W = 8;

  // Control field positions.
  localparam int unsigned BIT_EN       = 7;
  localparam int unsigned BIT_PERIODIC = 6;
  localparam int unsigned BIT_PRE_HI   = 3;
  localparam int unsigned BIT_PRE_LO   = 2;
  localparam int unsigned BIT_WIDE     = 1;
  localparam int unsigned BIT_ONESHOT  = 0;
  localparam logic [CTL_W-1:0] CTL_KEEP = 8'hCF;

  // Word selects inside a channel window.
  localparam logic [1:0] SEL_LOAD   = 2'd0;
  localparam logic [1:0] SEL_VALUE  = 2'd1;
  localparam logic [1:0] SEL_CTL    = 2'd2;
  localparam logic [1:0] SEL_RELOAD = 2'd3;

  // Word selects inside the shared window.
  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_RAW  = 2'd1;
  localparam logic [1:0] SEL_MIS  = 2'd2;
  localparam logic [1:0] SEL_CLR  = 2'd3;

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned PRE_MID  = 4,
  parameter int unsigned PRE_HI   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       stb,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  curVal,
  output logic [CTL_W-1:0]  ctlVal,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              hit
);

  localparam logic [CNT_W-1:0] NARROW_MASK =
    {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [PRE_HI-1:0] MID_LAST = PRE_HI'((1 << PRE_MID) - 1);

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  bgQ;
  logic [CTL_W-1:0]  ctlQ;
  logic [PRE_HI-1:0] preQ;
  logic [PRE_HI-1:0] preLast;
  logic [CNT_W-1:0]  widthMask;
  logic [CNT_W-1:0]  eff;
  logic [CNT_W-1:0]  wrapVal;
  logic              en;
  logic              tick;

  assign en        = ctlQ[BIT_EN];
  assign widthMask = ctlQ[BIT_WIDE] ? '1 : NARROW_MASK;
  assign eff       = cntQ & widthMask;
  assign wrapVal   = ctlQ[BIT_PERIODIC] ? (bgQ & widthMask) : widthMask;

  always_comb begin
    case (ctlQ[BIT_PRE_HI:BIT_PRE_LO])
      2'b00:   preLast = '0;
      2'b01:   preLast = MID_LAST;
      default: preLast = '1;
    endcase
  end

  assign tick = en && (preQ >= preLast);

  // Divider: restarts on disable or immediate load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    preQ <= '0;
    else if (!en || stb.loadWr)   preQ <= '0;
    else if (tick)                preQ <= '0;
    else                          preQ <= preQ + PRE_HI'(1);
  end

  // Count register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (stb.loadWr) begin
      cntQ <= wrData & widthMask;
    end else if (tick) begin
      if (eff != '0)                cntQ <= eff - CNT_W'(1);
      else if (!ctlQ[BIT_ONESHOT])  cntQ <= wrapVal;
    end
  end

  // Reload value: set by either load path.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             bgQ <= '0;
    else if (stb.loadWr || stb.reloadWr)   bgQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctlQ <= '0;
    else if (stb.ctlWr)  ctlQ <= wrData[CTL_W-1:0] & CTL_KEEP;
  end

  assign hit       = tick && !stb.loadWr && (eff == CNT_W'(1));
  assign curVal    = eff;
  assign ctlVal    = ctlQ;
  assign reloadVal = bgQ;

  // R4: a disabled channel without a load keeps its count.
  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !stb.loadWr) |=> $stable(cntQ));

  // R4: each tick on a nonzero count steps down by exactly one.
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !stb.loadWr && !stb.ctlWr && eff != '0) |=> (curVal == $past(eff) - CNT_W'(1)));

  // R9: a one-shot channel resting at zero stays there.
  p_oneshot_rest_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ[BIT_ONESHOT] && eff == '0 && !stb.loadWr && !stb.ctlWr) |=> (curVal == '0));

  // R5: with a divider above one, no tick comes right after a load.
  p_full_period_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadWr && en && ctlQ[BIT_PRE_HI:BIT_PRE_LO] != 2'b00) |=> !tick);

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned PRE_MID  = 4,
  parameter int unsigned PRE_HI   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chanStrobe_t [NUM_CH-1:0]      stb,
  input  logic [CNT_W-1:0]              wrData,
  output logic [NUM_CH-1:0][CNT_W-1:0]  curVal,
  output logic [NUM_CH-1:0][CTL_W-1:0]  ctlVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  reloadVal,
  output logic [NUM_CH-1:0]             hit
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tmr_channel #(
      .CNT_W    (CNT_W),
      .NARROW_W (NARROW_W),
      .PRE_MID  (PRE_MID),
      .PRE_HI   (PRE_HI)
    ) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .stb       (stb[ch]),
      .wrData    (wrData),
      .curVal    (curVal[ch]),
      .ctlVal    (ctlVal[ch]),
      .reloadVal (reloadVal[ch]),
      .hit       (hit[ch])
    );
  end

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wrEn,
  input  logic [NUM_CH-1:0]             clrData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  curVal,
  input  logic [NUM_CH-1:0][CTL_W-1:0]  ctlVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  reloadVal,
  input  logic [NUM_CH-1:0]             hit,
  output chanStrobe_t [NUM_CH-1:0]      stb,
  output logic [CNT_W-1:0]              rdData,
  output logic                          irqOut
);

  localparam int unsigned GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0]  grp;
  logic [1:0]        sel;
  logic              aligned;
  logic              sharedHit;
  logic              sharedWr;
  logic [NUM_CH-1:0] maskQ;
  logic [NUM_CH-1:0] rawQ;
  logic [NUM_CH-1:0] clrBits;

  assign grp       = addr[ADDR_W-1:4];
  assign sel       = addr[3:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign sharedHit = aligned && (grp == '0);
  assign sharedWr  = wrEn && sharedHit;

  // Strobes towards the datapath.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_stb
    logic chanHit;
    assign chanHit            = wrEn && aligned && (grp == GRP_W'(ch + 1));
    assign stb[ch].loadWr     = chanHit && (sel == SEL_LOAD);
    assign stb[ch].reloadWr   = chanHit && (sel == SEL_RELOAD);
    assign stb[ch].ctlWr      = chanHit && (sel == SEL_CTL);
  end

  assign clrBits = (sharedWr && sel == SEL_CLR) ? clrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              maskQ <= '0;
    else if (sharedWr && sel == SEL_MASK)   maskQ <= clrData;
  end

  // Event set wins over clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= (rawQ & ~clrBits) | hit;
  end

  assign irqOut = |(rawQ & maskQ);

  always_comb begin
    rdData = '0;
    if (sharedHit) begin
      case (sel)
        SEL_MASK: rdData = CNT_W'(maskQ);
        SEL_RAW:  rdData = CNT_W'(rawQ);
        SEL_MIS:  rdData = CNT_W'(rawQ & maskQ);
        default:  rdData = '0;
      endcase
    end else if (aligned) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (grp == GRP_W'(ch + 1)) begin
          case (sel)
            SEL_VALUE: rdData = curVal[ch];
            SEL_CTL:   rdData = CNT_W'(ctlVal[ch]);
            default:   rdData = reloadVal[ch];
          endcase
        end
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R10: a raw event stays set until its clear bit is written.
    p_raw_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
      (rawQ[ch] && !clrBits[ch]) |=> rawQ[ch]);
    // R10: a zero crossing always leaves the raw bit set.
    p_hit_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
      hit[ch] |=> rawQ[ch]);
  end

endmodule

// File: rtl/quad_timer.sv
module quad_timer
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned PRE_MID  = 4,
  parameter int unsigned PRE_HI   = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);

  chanStrobe_t [NUM_CH-1:0]      stb;
  logic [NUM_CH-1:0][CNT_W-1:0]  curVal;
  logic [NUM_CH-1:0][CTL_W-1:0]  ctlVal;
  logic [NUM_CH-1:0][CNT_W-1:0]  reloadVal;
  logic [NUM_CH-1:0]             hit;

  tmr_ctrl #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrEn      (wrEn),
    .clrData   (wrData[NUM_CH-1:0]),
    .curVal    (curVal),
    .ctlVal    (ctlVal),
    .reloadVal (reloadVal),
    .hit       (hit),
    .stb       (stb),
    .rdData    (rdData),
    .irqOut    (irq)
  );

  tmr_datapath #(
    .NUM_CH   (NUM_CH),
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W),
    .PRE_MID  (PRE_MID),
    .PRE_HI   (PRE_HI)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .curVal    (curVal),
    .ctlVal    (ctlVal),
    .reloadVal (reloadVal),
    .hit       (hit)
  );

endmodule

// File: tb/tb_quad_timer.sv
`timescale 1ns/1ps
module tb_quad_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  bit [31:0] mCnt [4];
  bit [31:0] mBg  [4];
  bit [7:0]  mCtl [4];
  int        mPre [4];
  bit [3:0]  mRaw;
  bit [3:0]  mMask;

  always #4 clk = ~clk;

  quad_timer dut (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .irq    (irq)
  );

  function automatic bit [31:0] widthOf(int ch);
    return mCtl[ch][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic bit [31:0] modelRead(bit [7:0] a);
    int g = a >> 4;
    int s = (a >> 2) & 3;
    if (a[1:0] != 2'b00) return 32'd0;
    if (g == 0) begin
      if (s == 0) return {28'd0, mMask};
      if (s == 1) return {28'd0, mRaw};
      if (s == 2) return {28'd0, mRaw & mMask};
      return 32'd0;
    end
    if (g > 4) return 32'd0;
    if (s == 1) return mCnt[g-1] & widthOf(g-1);
    if (s == 2) return {24'd0, mCtl[g-1]};
    return mBg[g-1];
  endfunction

  task automatic modelStep(bit we, bit [7:0] a, bit [31:0] d);
    bit [3:0] hits = '0;
    bit [3:0] clr = '0;
    int g = a >> 4;
    int s = (a >> 2) & 3;
    bit ok = (a[1:0] == 2'b00);
    for (int ch = 0; ch < 4; ch++) begin
      bit en = mCtl[ch][7];
      int ps = mCtl[ch][3:2];
      int div = (ps == 0) ? 1 : ((ps == 1) ? 16 : 256);
      bit tk = en && (mPre[ch] >= div - 1);
      bit [31:0] wm = widthOf(ch);
      bit [31:0] cur = mCnt[ch] & wm;
      bit ld = we && ok && (g == ch + 1) && (s == 0);
      if (!en || ld || tk) mPre[ch] = 0;
      else mPre[ch] = mPre[ch] + 1;
      if (ld) begin
        mCnt[ch] = d & wm;
        mBg[ch] = d;
      end else if (tk) begin
        if (cur != 0) begin
          if (cur == 1) hits[ch] = 1'b1;
          mCnt[ch] = cur - 1;
        end else if (!mCtl[ch][0]) begin
          mCnt[ch] = mCtl[ch][6] ? (mBg[ch] & wm) : wm;
        end
      end
      if (we && ok && (g == ch + 1) && (s == 3)) mBg[ch] = d;
      if (we && ok && (g == ch + 1) && (s == 2)) mCtl[ch] = d[7:0] & 8'hCF;
    end
    if (we && ok && g == 0 && s == 0) mMask = d[3:0];
    if (we && ok && g == 0 && s == 3) clr = d[3:0];
    mRaw = (mRaw & ~clr) | hits;
  endtask

  task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // One bus cycle; compares irq and (for reads) the read data.
  task automatic busCycle(bit we, bit [7:0] a, bit [31:0] d, string tag);
    @(negedge clk);
    addr = a;
    wrEn = we;
    wrData = d;
    #1;
    check("R11 irq", {31'd0, irq}, {31'd0, (|(mRaw & mMask))});
    if (!we) check(tag, rdData, modelRead(a));
    @(posedge clk);
    modelStep(we, a, d);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d, string tag);
    busCycle(1'b1, a, d, tag);
  endtask

  task automatic rdRun(bit [7:0] a, int n, string tag);
    for (int i = 0; i < n; i++) busCycle(1'b0, a, 32'd0, tag);
  endtask

  initial begin
    for (int ch = 0; ch < 4; ch++) begin
      mCnt[ch] = 0; mBg[ch] = 0; mCtl[ch] = 0; mPre[ch] = 0;
    end
    mRaw = 0; mMask = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register.
    for (int a = 0; a < 'h50; a += 4) busCycle(1'b0, 8'(a), 32'd0, "R1 reset value");

    // R2: control keeps only defined bits; unmapped and unaligned reads.
    wr(8'h18, 32'hFFFF_FF30, "R2");
    rdRun(8'h18, 1, "R2 control readback");
    wr(8'h18, 32'h0, "R2");
    rdRun(8'h50, 1, "R2 unmapped read");
    wr(8'h11, 32'h55, "R2");
    rdRun(8'h14, 1, "R2 unaligned write ignored");

    // R3/R4: load on a disabled channel, count holds.
    wr(8'h10, 32'd5, "R3");
    rdRun(8'h14, 3, "R3 R4 disabled hold");
    rdRun(8'h1C, 1, "R3 reload follows load");

    // R8/R10/R11: channel 0 periodic, 32-bit, divide by one.
    wr(8'h00, 32'hF, "R11");
    wr(8'h18, 32'hC2, "R4");
    wr(8'h1C, 32'd2, "R8 deferred write");
    rdRun(8'h14, 14, "R8 periodic count");
    rdRun(8'h08, 2, "R11 masked status");
    wr(8'h0C, 32'h1, "R10 clear");
    rdRun(8'h04, 2, "R10 raw status");
    for (int i = 0; i < 10; i++) wr(8'h0C, 32'h1, "R10 clear race");
    rdRun(8'h04, 1, "R10 set beats clear");
    wr(8'h18, 32'h00, "R4");

    // R5/R6/R7: channel 1 free-running, 16-bit, divide by 16.
    wr(8'h28, 32'h84, "R5");
    wr(8'h20, 32'h0001_0002, "R6 narrow load");
    rdRun(8'h24, 60, "R5 R7 narrow wrap");
    wr(8'h20, 32'h0001_2345, "R6");
    rdRun(8'h24, 2, "R6 upper bits zero");
    wr(8'h28, 32'h00, "R4");

    // R9: channel 2 one-shot, 32-bit, divide by 256.
    wr(8'h38, 32'h8B, "R9");
    wr(8'h30, 32'd2, "R9 load");
    rdRun(8'h34, 800, "R5 R9 one-shot rest");
    rdRun(8'h04, 1, "R10 raw after one-shot");

    // R7: channel 3 free-running 32-bit, load zero.
    wr(8'h48, 32'h82, "R7");
    wr(8'h40, 32'd0, "R7 zero load");
    rdRun(8'h44, 4, "R7 wide wrap");

    // R11: mask subset.
    wr(8'h00, 32'h2, "R11");
    rdRun(8'h08, 2, "R11 masked subset");
    wr(8'h0C, 32'hF, "R10");
    wr(8'h00, 32'h0, "R11");
    rdRun(8'h04, 2, "R10 R11 after clear");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule